// File: doc/BRIEF.md
# Memory-Mapped SPI Master with Frame FIFOs

This block is an SPI master that a processor drives through a six-word register bank. Software sets the frame width (4 to 16 bits), the clock polarity and phase, and a serial clock made from two divider stages. It then writes frames into an 8-deep transmit FIFO. Each frame is shifted out MSB first on `mosi`. During the same frame the block collects exactly one frame from `miso`, or from `mosi` itself in loopback mode, and places it in an 8-deep receive FIFO. Software reads the receive FIFO back through the same data word.

The bus is a plain single-cycle register port. A write takes effect at the clock edge on which `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr`, and a read of the data word pops the receive FIFO at that edge. Inside the block the two FIFOs exchange frames with the shifter over valid/ready handshakes, and back-pressure is applied at two points. A frame is loaded only when the shifter is idle and the port is enabled. A completed frame that meets a full receive FIFO is dropped and flagged as an overrun. Three level conditions, each masked by an enable bit, are ORed into a single interrupt output.

Register words, by byte address: 0x00 frame control, 0x04 port control, 0x08 data, 0x0C status, 0x10 prescaler, 0x14 interrupt flags (read) and overrun clear (write).

Top module: `sync_serial_master`

## Requirements
- R1: After reset the control, port-control and prescaler words read 0. Status reads 0x0003, the interrupt flags read 0x0002, `irq` is low, `sclk` is low and `busy` is low.
- R2: A data-word write pushes the transmit FIFO, and the write is dropped when 8 frames are already queued. A data-word read returns and pops the oldest received frame, and reads 0 without popping when the FIFO is empty.
- R3: Frame control bits 3:0 hold the frame width minus one, and a value below 3 acts as a width of 4. Frames go out MSB first, and transmit bits above the width are ignored. Received frames are right-justified with zeros above the width.
- R4: Each SCLK half period lasts (P/2)*(1+S) clocks, where S is frame control bits 15:8 and P is the prescaler word. Bit 0 of P always reads 0, and a P below 2 acts as 2. A frame of N bits produces exactly 2N SCLK edges.
- R5: Frame control bit 6 sets the SCLK idle level. With bit 7 clear, data is sampled on the first edge of each bit. With bit 7 set, data is sampled on the second edge.
- R6: With port-control bit 3 set, the receiver takes `mosi` and `miso` is ignored. With it clear, the receiver takes `miso`.
- R7: Status bits: 0 is transmit FIFO empty, 1 is transmit FIFO not full, 2 is receive FIFO not empty, 3 is receive FIFO full, and 4 is busy. Busy means a frame is shifting or the transmit FIFO is non-empty, and the `busy` pin carries the same value.
- R8: A frame that completes while the receive FIFO is full is discarded, and the stored frames are kept. Interrupt-flag bit 2 is then set and stays set until any write to 0x14.
- R9: Interrupt-flag bit 0 is set while the receive FIFO holds at least 4 frames, and bit 1 while the transmit FIFO holds at most 4. `irq` is the OR of flag bits 2:0, each masked by port-control bits 2:0 in the same order.
- R10: While port-control bit 4 is clear, no frame starts and a frame in progress is abandoned. SCLK then rests at its idle level and both FIFOs keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined masked interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame shifting or transmit data pending |

## Verification
Register writes take effect at the edge that accepts them, and read data is checked in the same cycle the address is presented. A pushed frame is loaded one clock after the push and starts shifting on the next. It finishes after 2N half periods, and the received frame, the status bits and the interrupt flags change at the clock edge where `busy` falls. The bench therefore waits for `busy` to fall before it reads back any frame or flag. A per-clock monitor two time units after each rising edge counts SCLK edges, measures the spacing between them, drives `miso` from a slave model, and checks the idle SCLK level against the polarity that was last written.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DATA_W   = 16;
  localparam int LEN_W    = 4;
  localparam int MIN_BITS = 4;
  localparam int PRE_W    = 8;
  localparam int SCR_W    = 8;
  localparam int REG_AW   = 5;

  localparam logic [REG_AW-1:0] A_FRAME = 5'h00;
  localparam logic [REG_AW-1:0] A_PORT  = 5'h04;
  localparam logic [REG_AW-1:0] A_DATA  = 5'h08;
  localparam logic [REG_AW-1:0] A_STAT  = 5'h0C;
  localparam logic [REG_AW-1:0] A_PRESC = 5'h10;
  localparam logic [REG_AW-1:0] A_IRQ   = 5'h14;

  typedef struct packed {
    logic port_en;
    logic loop;
    logic ror_ie;
    logic tx_ie;
    logic rx_ie;
  } port_ctl_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign in_ready  = (cnt_q != CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_q];
  assign count     = cnt_q;
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int PW = 7,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] pre_half,
  input  logic [SW-1:0] scr,
  output logic          tick
);
  logic [PW-1:0] pre_q, pre_lim;
  logic [SW-1:0] scr_q;
  logic          pre_wrap;

  // first stage counts half the even prescaler, second stage counts 1+S wraps
  assign pre_lim  = (pre_half == '0) ? '0 : pre_half - 1'b1;
  assign pre_wrap = (pre_q == pre_lim);
  assign tick     = run & pre_wrap & (scr_q == scr);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q <= '0;
      scr_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      scr_q <= (scr_q == scr) ? '0 : scr_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W  = 16,
  parameter int LW = 4,
  parameter int MB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          loop,
  input  logic [LW-1:0] len_m1,
  input  logic          tick,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [W-1:0]  rx_data,
  input  logic          rx_ready,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          active,
  output logic          drop
);
  localparam int HW = LW + 1;

  logic [LW-1:0] lm1_eff, lm1_q, sh_amt;
  logic [HW-1:0] ph_q, last_ph;
  logic [W-1:0]  tsh_q, rsh_q;
  logic          act_q, load, frame_end, din;

  assign lm1_eff   = (len_m1 < LW'(MB - 1)) ? LW'(MB - 1) : len_m1;
  assign sh_amt    = LW'(W - 1) - lm1_eff;
  assign last_ph   = {lm1_q, 1'b1};
  assign tx_ready  = en & ~act_q;
  assign load      = tx_valid & tx_ready;
  assign frame_end = act_q & en & tick & (ph_q == last_ph);
  assign din       = loop ? tsh_q[W-1] : miso;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      lm1_q <= '0;
      tsh_q <= '0;
      rsh_q <= '0;
    end else if (load) begin
      act_q <= 1'b1;
      ph_q  <= '0;
      lm1_q <= lm1_eff;
      tsh_q <= tx_data << sh_amt;
      rsh_q <= '0;
    end else if (act_q) begin
      if (!en) begin
        act_q <= 1'b0;
      end else if (tick) begin
        if (ph_q == last_ph) begin
          act_q <= 1'b0;
        end else begin
          ph_q <= ph_q + 1'b1;
          if (!ph_q[0]) rsh_q <= {rsh_q[W-2:0], din};
          else          tsh_q <= tsh_q << 1;
        end
      end
    end
  end

  assign rx_valid = frame_end;
  assign rx_data  = rsh_q;
  assign drop     = frame_end & ~rx_ready;
  assign active   = act_q;
  assign mosi     = tsh_q[W-1];
  assign sclk     = act_q ? (cpol ^ cpha ^ ph_q[0]) : cpol;
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssp_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              busy
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int HALF = FIFO_DEPTH / 2;

  logic [LEN_W-1:0]   lm1_q;
  logic               cpol_q, cpha_q;
  logic [SCR_W-1:0]   scr_q;
  logic [PRE_W-2:0]   pre_half_q;
  port_ctl_t          ctrl1_q;
  logic               ror_q;

  logic               wr, rd, tx_push, rx_pop;
  logic               txf_in_rdy, txf_vld, rxf_in_rdy, rxf_vld;
  logic [DATA_W-1:0]  txf_data, rxf_data, sh_rx_data;
  logic [CW-1:0]      tx_cnt, rx_cnt;
  logic               sh_tx_rdy, sh_rx_vld, sh_drop, sh_active, tick;
  logic [2:0]         raw;

  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign tx_push = wr & (bus_addr == A_DATA);
  assign rx_pop  = rd & (bus_addr == A_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lm1_q      <= '0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      scr_q      <= '0;
      pre_half_q <= '0;
      ctrl1_q    <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_FRAME: begin
          lm1_q  <= bus_wdata[LEN_W-1:0];
          cpol_q <= bus_wdata[6];
          cpha_q <= bus_wdata[7];
          scr_q  <= bus_wdata[8 +: SCR_W];
        end
        A_PORT:  ctrl1_q    <= port_ctl_t'(bus_wdata[4:0]);
        A_PRESC: pre_half_q <= bus_wdata[PRE_W-1:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       ror_q <= 1'b0;
    else if (sh_drop)                 ror_q <= 1'b1;
    else if (wr && bus_addr == A_IRQ) ror_q <= 1'b0;
  end

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_push), .in_ready(txf_in_rdy), .in_data(bus_wdata),
    .out_valid(txf_vld), .out_ready(sh_tx_rdy), .out_data(txf_data),
    .count(tx_cnt)
  );

  ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sh_rx_vld), .in_ready(rxf_in_rdy), .in_data(sh_rx_data),
    .out_valid(rxf_vld), .out_ready(rx_pop), .out_data(rxf_data),
    .count(rx_cnt)
  );

  ssp_baud #(.PW(PRE_W - 1), .SW(SCR_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(sh_active & ctrl1_q.port_en),
    .pre_half(pre_half_q), .scr(scr_q), .tick(tick)
  );

  ssp_shifter #(.W(DATA_W), .LW(LEN_W), .MB(MIN_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(ctrl1_q.port_en),
    .cpol(cpol_q), .cpha(cpha_q), .loop(ctrl1_q.loop), .len_m1(lm1_q),
    .tick(tick),
    .tx_valid(txf_vld), .tx_data(txf_data), .tx_ready(sh_tx_rdy),
    .rx_valid(sh_rx_vld), .rx_data(sh_rx_data), .rx_ready(rxf_in_rdy),
    .miso(miso), .sclk(sclk), .mosi(mosi), .active(sh_active), .drop(sh_drop)
  );

  assign busy   = sh_active | txf_vld;
  assign raw[0] = (rx_cnt >= CW'(HALF));
  assign raw[1] = (tx_cnt <= CW'(HALF));
  assign raw[2] = ror_q;
  assign irq    = |(raw & {ctrl1_q.ror_ie, ctrl1_q.tx_ie, ctrl1_q.rx_ie});

  always_comb begin
    case (bus_addr)
      A_FRAME: bus_rdata = {scr_q, cpha_q, cpol_q, 2'b00, lm1_q};
      A_PORT:  bus_rdata = {11'd0, ctrl1_q};
      A_DATA:  bus_rdata = rxf_vld ? rxf_data : '0;
      A_STAT:  bus_rdata = {11'd0, busy, ~rxf_in_rdy, rxf_vld, txf_in_rdy, ~txf_vld};
      A_PRESC: bus_rdata = {8'd0, pre_half_q, 1'b0};
      A_IRQ:   bus_rdata = {13'd0, raw};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sync_serial_master_chk.sv
module sync_serial_master_chk
  import ssp_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic              sclk,
  input logic              busy,
  input logic              irq,
  input logic              cpol_q,
  input port_ctl_t         ctrl1_q,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              rx_pop,
  input logic              ror_q,
  input logic              sh_drop,
  input logic              sh_active
);
  logic irq_clr;
  assign irq_clr = bus_en & bus_we & (bus_addr == A_IRQ);

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (tx_cnt <= CW'(FIFO_DEPTH)) && (rx_cnt <= CW'(FIFO_DEPTH))); // R2
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (sclk == cpol_q)); // R5
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n) !ctrl1_q.port_en |=> !sh_active); // R10
  AST_DROP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (sh_drop && !rx_pop) |=> (rx_cnt == CW'(FIFO_DEPTH))); // R8
  AST_ROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ror_q && !irq_clr) |=> ror_q); // R8
  AST_ROR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (irq_clr && !sh_drop) |=> !ror_q); // R8
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (ctrl1_q.rx_ie || ctrl1_q.tx_ie || ctrl1_q.ror_ie)); // R9
endmodule

bind sync_serial_master sync_serial_master_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (.*);

// File: tb/sync_serial_master_bench.sv
module sync_serial_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, sclk, mosi, busy;
  logic        miso;

  int n_checks = 0, n_err = 0;
  // monitor / reference state
  logic m_cpol = 1'b0;
  logic prev_sclk = 1'b0;
  int   cyc = 0, edge_cnt = 0, last_edge = 0, gmin = 0, gmax = 0;
  bit   have_edge = 0;
  int   s_bits = 8;
  bit   s_cpha = 0;
  logic [15:0] s_word = 16'hFFFF;

  sync_serial_master u_sync_serial_master (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock reference: SCLK edge timing, idle level, slave model on miso
  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_n) begin
      if (!busy) ck("R5 idle sclk level", sclk, m_cpol);
      if (sclk !== prev_sclk) begin
        edge_cnt++;
        if (have_edge) begin
          if (cyc - last_edge < gmin) gmin = cyc - last_edge;
          if (cyc - last_edge > gmax) gmax = cyc - last_edge;
        end
        last_edge = cyc;
        have_edge = 1;
      end
    end
    prev_sclk = sclk;
    begin
      int e, idx;
      e   = edge_cnt % (2 * s_bits);
      idx = s_cpha ? s_bits - (e + 1) / 2 : s_bits - 1 - e / 2;
      miso = (idx >= 0 && idx < s_bits) ? s_word[idx] : 1'b0;
    end
  end

  task automatic reset_mon();
    edge_cnt = 0; have_edge = 0; gmin = 1 << 30; gmax = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 5'h00) m_cpol = d[6];
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_ck(input string tag, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    ck(tag, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    miso = 1'b0;
    reset_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_ck("R1 frame ctl", 5'h00, 16'h0000);
    rd_ck("R1 port ctl", 5'h04, 16'h0000);
    rd_ck("R1 prescaler", 5'h10, 16'h0000);
    rd_ck("R1 status", 5'h0C, 16'h0003);
    rd_ck("R1 irq flags", 5'h14, 16'h0002);
    ck("R1 irq pin", irq, 1'b0);
    ck("R1 sclk", sclk, 1'b0);
    ck("R1 busy", busy, 1'b0);
    rd_ck("R2 empty read", 5'h08, 16'h0000);

    // R3/R6 loopback 8-bit frames, MISO held high and ignored
    wr(5'h10, 16'h0002);
    wr(5'h00, 16'h0007);
    wr(5'h04, 16'h0018);
    wr(5'h08, 16'h005A);
    wr(5'h08, 16'h01C3);
    wait_idle();
    rd_ck("R6 loopback frame 0", 5'h08, 16'h005A);
    rd_ck("R3 upper bits ignored", 5'h08, 16'h00C3);

    // R3 width clamp and extremes
    wr(5'h00, 16'h0001);
    reset_mon();
    wr(5'h08, 16'h00FB);
    wait_idle();
    ck("R3 clamp width 4 edges", edge_cnt, 8);
    rd_ck("R3 width 4 frame", 5'h08, 16'h000B);
    wr(5'h00, 16'h000F);
    wr(5'h08, 16'hBEEF);
    wait_idle();
    rd_ck("R3 width 16 frame", 5'h08, 16'hBEEF);

    // R4 divider: P=7 reads 6, S=2 -> half period 9
    wr(5'h10, 16'h0007);
    rd_ck("R4 prescaler bit0", 5'h10, 16'h0006);
    wr(5'h00, 16'h0207);
    reset_mon();
    wr(5'h08, 16'h0033);
    rd_ck("R7 busy while shifting", 5'h0C, 16'h0013);
    wait_idle();
    ck("R4 edges per frame", edge_cnt, 16);
    ck("R4 min half period", gmin, 9);
    ck("R4 max half period", gmax, 9);
    rd_ck("R4 frame data", 5'h08, 16'h0033);
    wr(5'h10, 16'h0000);
    wr(5'h00, 16'h0007);
    reset_mon();
    wr(5'h08, 16'h0044);
    wait_idle();
    ck("R4 P=0 acts as 2 min", gmin, 1);
    ck("R4 P=0 acts as 2 max", gmax, 1);
    rd_ck("R4 fast frame", 5'h08, 16'h0044);

    // R5/R6 external MISO, CPOL=1 CPHA=1
    wr(5'h04, 16'h0010);
    wr(5'h00, 16'h00C7);
    s_word = 16'h0096; s_cpha = 1;
    reset_mon();
    ck("R5 idle high", sclk, 1'b1);
    wr(5'h08, 16'h0000);
    wait_idle();
    ck("R5 cpha1 edges", edge_cnt, 16);
    rd_ck("R5 cpha1 sample", 5'h08, 16'h0096);
    // CPOL=0 CPHA=0
    wr(5'h00, 16'h0007);
    s_word = 16'h00A5; s_cpha = 0;
    reset_mon();
    wr(5'h08, 16'h003C);
    wait_idle();
    rd_ck("R5 cpha0 sample", 5'h08, 16'h00A5);
    wr(5'h04, 16'h0018);
    reset_mon();
    wr(5'h08, 16'h003C);
    wait_idle();
    rd_ck("R6 miso ignored in loopback", 5'h08, 16'h003C);

    // R10/R7/R9: fill TX while disabled
    wr(5'h04, 16'h0008);
    reset_mon();
    for (int i = 0; i < 8; i++) wr(5'h08, 16'(8'h11 * i + 1));
    wr(5'h08, 16'h00EE);
    repeat (50) @(negedge clk);
    ck("R10 no edges while disabled", edge_cnt, 0);
    ck("R10 sclk rests", sclk, m_cpol);
    rd_ck("R7 tx full status", 5'h0C, 16'h0010);
    rd_ck("R9 flags tx full", 5'h14, 16'h0000);
    wr(5'h04, 16'h0018);
    wait_idle();
    rd_ck("R7 rx full status", 5'h0C, 16'h000F);
    rd_ck("R9 flags levels", 5'h14, 16'h0003);
    ck("R9 irq masked", irq, 1'b0);
    wr(5'h04, 16'h0019);
    ck("R9 rx irq enabled", irq, 1'b1);
    wr(5'h04, 16'h0018);
    for (int i = 0; i < 8; i++) rd_ck("R2 fifo order", 5'h08, 16'(8'h11 * i + 1));
    rd_ck("R2 full write dropped", 5'h08, 16'h0000);
    rd_ck("R7 empty status", 5'h0C, 16'h0003);

    // R8 overrun
    for (int i = 0; i < 8; i++) wr(5'h08, 16'(8'h80 + i));
    wait_idle();
    wr(5'h08, 16'h0077);
    wait_idle();
    rd_ck("R8 overrun flag", 5'h14, 16'h0007);
    wr(5'h04, 16'h001C);
    ck("R8 overrun irq", irq, 1'b1);
    for (int i = 0; i < 8; i++) rd_ck("R8 contents kept", 5'h08, 16'(8'h80 + i));
    rd_ck("R8 new frame discarded", 5'h08, 16'h0000);
    rd_ck("R8 flag sticky", 5'h14, 16'h0006);
    wr(5'h14, 16'h0000);
    rd_ck("R8 flag cleared", 5'h14, 16'h0002);
    ck("R8 irq cleared", irq, 1'b0);

    // R10 abort mid-frame: half period 100
    wr(5'h04, 16'h0018);
    wr(5'h10, 16'd20);
    wr(5'h00, 16'h0907);
    wr(5'h08, 16'h0055);
    repeat (150) @(negedge clk);
    wr(5'h04, 16'h0008);
    @(negedge clk);
    ck("R10 abort busy", busy, 1'b0);
    ck("R10 abort sclk", sclk, 1'b0);
    rd_ck("R10 abort status", 5'h0C, 16'h0003);
    reset_mon();
    wr(5'h04, 16'h0018);
    repeat (300) @(negedge clk);
    ck("R10 nothing resumes", edge_cnt, 0);
    rd_ck("R10 no frame received", 5'h08, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule